// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the sequence of column addresses for a single read or write burst of a synchronous DRAM. A command strobe loads a starting column together with a burst length code, an ordering select and a single-write override. From the next clock on, the block presents one column address per enabled clock. The addresses stay inside an aligned block whose size is the burst length, and they run in either sequential or interleaved order.

A full-page burst instead walks the whole 512-column row, wraps at the row's end and keeps going until a stop input ends it. A low clock enable freezes the sequence where it stands. A new command that arrives while a burst runs restarts the sequence from the new column. Outputs are the current column, a valid flag and a flag that marks the final beat.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `col_valid` = 0 and `col_last` = 0.
- R2: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats. `col_last` is high on exactly the final beat, and `col_valid` drops the cycle after it unless a new command is accepted.
- R3: In sequential order (`interleave` = 0), beat k of a burst of length L from column S shows (S − S mod L) + ((S mod L + k) mod L).
- R4: In interleaved order (`interleave` = 1), beat k shows (S − S mod L) + ((S mod L) XOR k).
- R5: Code 3'b111 with `interleave` = 0 starts a full-page burst: beat k shows (S + k) mod 512, and `col_last` is never high.
- R6: With `cke` high and no accepted command, a high `burst_stop` makes `col_valid` low in the next cycle.
- R7: A command with code 3'b100, 3'b101 or 3'b110, or with code 3'b111 together with `interleave` = 1, is ignored. An idle block stays idle, and a running burst continues unchanged.
- R8: When `wr_single` = 1, a write command (`cmd_write` = 1) gives a single beat at the start column. A read command keeps its programmed length.
- R9: While `cke` is low at an edge, the column, valid and last outputs hold, and `cmd_go` and `burst_stop` have no effect.
- R10: A legal command accepted during a running burst restarts the sequence at beat 0 of the new command.
- R11: The first beat appears in the cycle after the accepting edge, with `col_addr` equal to the start column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes all state |
| cmd_go | input | 1 | Command strobe that starts a burst |
| cmd_col | input | 9 | Starting column of the command |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| len_code | input | 3 | Burst length code |
| interleave | input | 1 | 0 = sequential order, 1 = interleaved order |
| wr_single | input | 1 | 1 = writes access one location only |
| burst_stop | input | 1 | Ends the running burst |
| col_addr | output | 9 | Column for the current beat |
| col_valid | output | 1 | High while a beat is presented |
| col_last | output | 1 | High on the final beat of a fixed-length burst |

## Verification
The bench drives start columns whose offset is not zero, so that a generator that carried into the upper column bits, or that ran the interleave with an add, shows an address outside the aligned block. A full-page burst starting near column 511 would show a design that stopped, flagged a last beat or failed to wrap at the row end. Reserved codes are issued both while the block is idle and during a burst, which catches a design that starts or kills a burst on them. Commands and stops issued under a low clock enable catch a frozen state that still responds. Randomised command, stop and enable traffic then mixes the write-single override, restarts and length changes against a model built from the address formulas.

// File: rtl/bcg_pkg.sv
// Package: shared codes for the burst column address generator.
// Assumes the length code field is three bits wide, as the command format fixes it.
package bcg_pkg;
    localparam int unsigned LEN_CODE_W = 3;

    typedef enum logic [LEN_CODE_W-1:0] {
        BL_ONE  = 3'b000,
        BL_TWO  = 3'b001,
        BL_FOUR = 3'b010,
        BL_EIGHT = 3'b011,
        BL_PAGE = 3'b111
    } bl_code_e;
endpackage

// File: rtl/bcg_len_decode.sv
// Module: bcg_len_decode
// Turns a length code, the ordering select and the single-write override into
// a legality flag, a full-page flag and a wrap mask (burst length minus one).
// Assumes COL_W >= 3, so that an 8-beat block fits inside the page.
module bcg_len_decode
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic                  ilv,
    input  logic                  is_write,
    input  logic                  wr_single,
    output logic                  legal,
    output logic                  full,
    output logic [COL_W-1:0]      mask
);

    // Decode the code to a mask, then apply the single-location override for writes.
    always_comb begin
        legal = 1'b1;
        full  = 1'b0;
        mask  = '0;
        case (len_code)
            BL_ONE:   mask = '0;
            BL_TWO:   mask = COL_W'(1);
            BL_FOUR:  mask = COL_W'(3);
            BL_EIGHT: mask = COL_W'(7);
            BL_PAGE: begin
                if (ilv) begin
                    legal = 1'b0;
                end else begin
                    full = 1'b1;
                    mask = '1;
                end
            end
            default:  legal = 1'b0;
        endcase
        if (is_write && wr_single) begin
            full = 1'b0;
            mask = '0;
        end
    end

endmodule

// File: rtl/bcg_addr_map.sv
// Module: bcg_addr_map
// Maps the start column and beat counter to the column of the current beat.
// Bits above the mask come from the start column; bits under the mask are the
// start offset plus (sequential) or XOR (interleaved) the counter.
// Assumes the counter never exceeds the mask for fixed-length bursts.
module bcg_addr_map #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] off;
    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_ilv;

    // Form both candidate low parts and merge with the aligned block base.
    always_comb begin
        off     = base_col & mask;
        low_seq = (off + cnt) & mask;
        low_ilv = (off ^ cnt) & mask;
        col     = (base_col & ~mask) | (ilv ? low_ilv : low_seq);
    end

endmodule

// File: rtl/bcg_seq_ctrl.sv
// Module: bcg_seq_ctrl
// Holds the burst state: active flag, beat counter and the captured command.
// Priority on an enabled edge: accepted command, then stop, then advance.
// Assumes legal/full/mask_in are decoded from the same-cycle command inputs.
module bcg_seq_ctrl #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             start,
    input  logic             legal,
    input  logic             full_in,
    input  logic [COL_W-1:0] mask_in,
    input  logic             ilv_in,
    input  logic [COL_W-1:0] start_col,
    input  logic             stop,
    output logic             act,
    output logic             last,
    output logic [COL_W-1:0] cnt,
    output logic [COL_W-1:0] base_q,
    output logic [COL_W-1:0] mask_q,
    output logic             ilv_q
);

    logic full_q;
    logic at_end;
    logic accept;

    // Final beat of a fixed-length burst: counter has reached the mask.
    always_comb begin
        at_end = !full_q && (cnt == mask_q);
        accept = cke && start && legal;
        last   = act && at_end;
    end

    // Burst state update; a low clock enable holds everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act    <= 1'b0;
            cnt    <= '0;
            base_q <= '0;
            mask_q <= '0;
            ilv_q  <= 1'b0;
            full_q <= 1'b0;
        end else if (cke) begin
            if (start && legal) begin
                act    <= 1'b1;
                cnt    <= '0;
                base_q <= start_col;
                mask_q <= mask_in;
                ilv_q  <= ilv_in;
                full_q <= full_in;
            end else if (stop) begin
                act <= 1'b0;
            end else if (act) begin
                if (at_end) begin
                    act <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R9: frozen state while the clock enable is low
    p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> $stable(act) && $stable(cnt) && $stable(base_q));

    // R5: a full-page burst never flags a last beat
    p_page_nolast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act && full_q |-> !last);

    // R2: the burst ends after its last beat
    p_end_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cke && last && !accept |=> !act);

    // R6: stop ends the burst on the next cycle
    p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cke && stop && !accept |=> !act);

    // R10: an accepted command restarts at beat zero
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> act && (cnt == '0));

    // R3: the counter stays inside the block of a fixed-length burst
    p_cnt_in_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act && !full_q |-> ((cnt & ~mask_q) == '0));

endmodule

// File: rtl/burst_col_gen.sv
// Module: burst_col_gen (top)
// Column address sequence generator for one DRAM read or write burst.
// Assumes commands and stop are sampled only on edges where cke is high.
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cke,
    input  logic                  cmd_go,
    input  logic [COL_W-1:0]      cmd_col,
    input  logic                  cmd_write,
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic                  interleave,
    input  logic                  wr_single,
    input  logic                  burst_stop,
    output logic [COL_W-1:0]      col_addr,
    output logic                  col_valid,
    output logic                  col_last
);

    logic             dec_legal;
    logic             dec_full;
    logic [COL_W-1:0] dec_mask;
    logic             st_act;
    logic             st_last;
    logic [COL_W-1:0] st_cnt;
    logic [COL_W-1:0] st_base;
    logic [COL_W-1:0] st_mask;
    logic             st_ilv;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .len_code  (len_code),
        .ilv       (interleave),
        .is_write  (cmd_write),
        .wr_single (wr_single),
        .legal     (dec_legal),
        .full      (dec_full),
        .mask      (dec_mask)
    );

    bcg_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke       (cke),
        .start     (cmd_go),
        .legal     (dec_legal),
        .full_in   (dec_full),
        .mask_in   (dec_mask),
        .ilv_in    (interleave),
        .start_col (cmd_col),
        .stop      (burst_stop),
        .act       (st_act),
        .last      (st_last),
        .cnt       (st_cnt),
        .base_q    (st_base),
        .mask_q    (st_mask),
        .ilv_q     (st_ilv)
    );

    bcg_addr_map #(.COL_W(COL_W)) u_map (
        .base_col (st_base),
        .cnt      (st_cnt),
        .mask     (st_mask),
        .ilv      (st_ilv),
        .col      (col_addr)
    );

    // Drive the beat flags straight from the burst state.
    always_comb begin
        col_valid = st_act;
        col_last  = st_last;
    end

    // R7: a reserved code never starts a burst from idle
    p_reserved_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cke && cmd_go && !col_valid && !burst_stop &&
        ((len_code[2] && (len_code != 3'b111)) || (len_code == 3'b111 && interleave))
        |=> !col_valid);

    // R11: first beat presents the start column
    p_first_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cke && cmd_go && !len_code[2] |=> col_valid && (col_addr == $past(cmd_col)));

    // R1: flags are low after a reset edge
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !col_valid && !col_last);

endmodule

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;
    localparam int COLS = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       go = 1'b0;
    logic [8:0] col = '0;
    logic       wr = 1'b0;
    logic [2:0] code = '0;
    logic       ilv = 1'b0;
    logic       wrs = 1'b0;
    logic       stop = 1'b0;
    logic [8:0] col_addr;
    logic       col_valid;
    logic       col_last;

    int checks = 0;
    int failures = 0;

    // expected-state model
    bit    m_act = 0;
    int    m_k = 0;
    int    m_s = 0;
    int    m_len = 1;
    bit    m_full = 0;
    bit    m_ilv = 0;
    string pend_tag = "R1";

    always #2.5 clk = ~clk;

    burst_col_gen u0 (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cmd_go(go), .cmd_col(col),
        .cmd_write(wr), .len_code(code), .interleave(ilv), .wr_single(wrs),
        .burst_stop(stop), .col_addr(col_addr), .col_valid(col_valid),
        .col_last(col_last)
    );

    function automatic int exp_col(int s, int k, int len, bit full, bit il);
        int base;
        int off;
        if (full) return (s + k) % COLS;
        base = s - (s % len);
        off  = s % len;
        if (il) return base + (off ^ k);
        return base + ((off + k) % len);
    endfunction

    function automatic bit is_legal(int c, bit il);
        return (c <= 3) || (c == 7 && !il);
    endfunction

    task automatic finish_tb();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic compare();
        bit exp_last;
        int ec;
        checks++;
        if (!m_act) begin
            if (col_valid !== 1'b0 || col_last !== 1'b0) begin
                failures++;
                $display("FAIL %s: valid=%0b last=%0b expected valid=0 last=0",
                         pend_tag, col_valid, col_last);
            end
        end else begin
            exp_last = !m_full && (m_k == m_len - 1);
            ec = exp_col(m_s, m_k, m_len, m_full, m_ilv);
            if (col_valid !== 1'b1 || col_last !== exp_last || int'(col_addr) != ec) begin
                failures++;
                $display("FAIL %s: valid=%0b last=%0b col=%0d expected valid=1 last=%0b col=%0d",
                         pend_tag, col_valid, col_last, col_addr, exp_last, ec);
            end
        end
    endtask

    // compare current outputs, drive new inputs, predict state after next edge
    task automatic step(bit g, int c_col, bit w, int c, bit il, bit ws, bit st, bit en, string tag);
        @(negedge clk);
        compare();
        go = g; col = 9'(c_col); wr = w; code = 3'(c); ilv = il; wrs = ws; stop = st; cke = en;
        if (en) begin
            if (g && is_legal(c, il)) begin
                m_act = 1; m_k = 0; m_s = c_col; m_ilv = il;
                if (w && ws) begin
                    m_len = 1; m_full = 0;
                end else if (c == 7) begin
                    m_len = COLS; m_full = 1;
                end else begin
                    m_len = 1 << c; m_full = 0;
                end
            end else if (st) begin
                m_act = 0;
            end else if (m_act) begin
                if (!m_full && m_k == m_len - 1) m_act = 0;
                else m_k = (m_k + 1) % m_len;
            end
        end
        if (tag != "") pend_tag = tag;
        else if (!en) pend_tag = "R9";
        else if (m_full) pend_tag = "R5";
        else if (m_ilv) pend_tag = "R4";
        else pend_tag = "R3";
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 1, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_tb();
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        pend_tag = "R1";
        m_act = 0;
        compare();
        rst_n = 1'b1;

        // R11, R3: sequential 8-beat burst from offset 5
        step(1, 9'h1D5, 0, 3, 0, 0, 0, 1, "R11");
        idle(9, "R3");
        // R2: lengths 1, 2, 4
        step(1, 9'h033, 0, 0, 0, 0, 0, 1, "R2");
        idle(2, "R2");
        step(1, 9'h033, 0, 1, 0, 0, 0, 1, "R2");
        idle(3, "R2");
        step(1, 9'h036, 0, 2, 0, 0, 0, 1, "R2");
        idle(5, "R2");
        // R4: interleaved 8-beat and 4-beat
        step(1, 9'h0F3, 0, 3, 1, 0, 0, 1, "R4");
        idle(9, "R4");
        step(1, 9'h10E, 1, 2, 1, 0, 0, 1, "R4");
        idle(5, "R4");
        // R5, R6: full page across the row end, then stop
        step(1, 9'h1FE, 0, 7, 0, 0, 0, 1, "R5");
        idle(530, "R5");
        step(0, 0, 0, 0, 0, 0, 1, 1, "R6");
        idle(2, "R6");
        // R7: reserved codes while idle and during a burst
        step(1, 9'h040, 0, 4, 0, 0, 0, 1, "R7");
        step(1, 9'h040, 0, 7, 1, 0, 0, 1, "R7");
        idle(1, "R7");
        step(1, 9'h0A2, 0, 3, 0, 0, 0, 1, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R7");
        step(1, 9'h150, 0, 5, 0, 0, 0, 1, "R7");
        step(1, 9'h150, 1, 7, 1, 0, 0, 1, "R7");
        step(1, 9'h150, 0, 6, 1, 0, 0, 1, "R7");
        idle(6, "R7");
        // R8: single-location writes, reads keep length
        step(1, 9'h0C5, 1, 3, 0, 1, 0, 1, "R8");
        idle(3, "R8");
        step(1, 9'h0C5, 1, 7, 0, 1, 0, 1, "R8");
        idle(3, "R8");
        step(1, 9'h0C5, 0, 2, 0, 1, 0, 1, "R8");
        idle(5, "R8");
        // R9: freeze with command and stop asserted under low enable
        step(1, 9'h011, 0, 3, 0, 0, 0, 1, "R9");
        idle(2, "R9");
        step(1, 9'h1F0, 0, 1, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 1, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R9");
        idle(8, "R9");
        // R10: restart mid burst
        step(1, 9'h067, 0, 3, 0, 0, 0, 1, "R10");
        idle(3, "R10");
        step(1, 9'h1A9, 0, 2, 1, 0, 0, 1, "R10");
        idle(2, "R10");
        step(1, 9'h1AA, 0, 3, 1, 0, 0, 1, "R10");
        idle(9, "R10");

        // random traffic with a fixed seed
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4000; i++) begin
            bit g  = ($urandom % 8) == 0;
            bit st = ($urandom % 24) == 0;
            bit en = ($urandom % 4) != 0;
            int cc = ($urandom % 5 == 0) ? 7 : int'($urandom % 8);
            step(g, int'($urandom % COLS), 1'($urandom), cc, 1'($urandom),
                 ($urandom % 4) == 0, st, en, "");
        end
        idle(2, "");
        @(negedge clk);
        compare();
        finish_tb();
    end
endmodule